// File: doc/BRIEF.md
# Serial Flash Identification and Geometry Probe

This block performs the power-up discovery of a page-organised serial flash that hangs off a byte-wide SPI master. A single start pulse makes it read the identification bytes, reject anything that is not the expected vendor and family, and turn the capacity code into a page-size shift and a page count. It then polls the status byte until the device is ready and inspects the page-size configuration bit.

The SPI side is a byte handshake. The block raises `spi_req` with a byte on `spi_tx` and holds both until the shifter returns `spi_ack` for one cycle with the received byte on `spi_rx`. `spi_cs` frames each command. When the device is still in its non-power-of-two page mode, the block sends the one-shot reconfiguration sequence and finishes with a failure, because the new page size only takes effect after a power cycle. The result comes with a one-cycle `done` pulse and stays stable until the next start.

Top module: `flash_id_probe`

## Requirements
- R1: After reset, and whenever no probe is running, `spi_cs` and `spi_req` are low, `done` is low and `err_code` is 0. A probe begins only on `start`, and `spi_cs` is low at every `done` pulse.
- R2: Identification uses one chip-select window of exactly four bytes: 0x9F, then three 0xFF fill bytes. The replies to fill bytes 1 and 2 are taken as the vendor byte and the device byte.
- R3: If the vendor byte is not 0x1F, or bits 7:5 of the device byte are not 001, the probe ends with `err_code` 1, `page_shift` 0, `page_count` 0 and no status poll.
- R4: Bits 4:0 of the device byte select the geometry (shift, pages): 2→(8,512), 3→(8,1024), 4→(8,2048), 5→(8,4096), 6→(9,4096), 7→(9,8192), 8→(10,8192). `page_size` equals 1 shifted left by `page_shift`.
- R5: Any other capacity code ends the probe with `err_code` 2, `page_shift` 0 and `page_count` 0, with no status poll.
- R6: After a valid identification, the status is read with repeated two-byte windows (0xD7, 0xFF) until bit 7 of the reply is 1. `status_byte` holds the last reply.
- R7: If MAX_POLLS windows all return bit 7 clear, the probe ends with `err_code` 4 and sends no further windows. A ready reply on poll MAX_POLLS still succeeds.
- R8: If the ready status has bit 0 clear, one window carrying 0x3D, 0x2A, 0x80, 0xA6 is sent, `reprog_issued` is set and `err_code` is 3. The decoded geometry stays on the outputs.
- R9: `done` is a single-cycle pulse. `ok` is 1 at `done` exactly when `err_code` is 0, which happens only when the ready status has bit 0 set.
- R10: A `start` pulse while a probe is running has no effect: one `done`, one identification window.
- R11: Once `spi_req` is raised, it and `spi_tx` are held steady until `spi_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that launches a probe |
| done | output | 1 | One-cycle end-of-probe pulse |
| ok | output | 1 | Probe succeeded |
| err_code | output | 3 | 0 none, 1 no device, 2 unknown capacity, 3 reconfigured, 4 ready timeout |
| page_shift | output | 4 | log2 of page size |
| page_count | output | 14 | Number of pages (also the erase-block count) |
| page_size | output | 11 | Page size in bytes (also the erase size) |
| reprog_issued | output | 1 | Page-size reconfiguration was sent |
| status_byte | output | 8 | Last status reply |
| spi_cs | output | 1 | Chip select, active high |
| spi_req | output | 1 | Byte transfer request |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Transfer complete, one cycle |
| spi_rx | input | 8 | Byte received with `spi_ack` |

## Verification
Some rules are checked by assertions on every cycle: the byte request is held steady while unacknowledged, `done` is a single pulse with chip select released, `ok` agrees with the error code, the reprogram flag only comes with its error code, and a reported page size matches its shift. The bench's scenarios are needed for the rest. They cover the exact byte content of each window, the full capacity table, the number of status polls on either side of the timeout limit, and the fact that a start issued mid-probe is ignored.

// File: rtl/fid_pkg.sv
// Shared constants and types for the flash identification probe.
// Assumes the device answers with one byte per byte sent.
package fid_pkg;
    localparam int SHIFT_W = 4;
    localparam int COUNT_W = 14;
    localparam int SIZE_W  = 11;

    localparam logic [7:0]  OPC_IDENT  = 8'h9F;
    localparam logic [7:0]  OPC_STATUS = 8'hD7;
    localparam logic [7:0]  FILL_BYTE  = 8'hFF;
    localparam logic [7:0]  VENDOR_ID  = 8'h1F;
    localparam logic [2:0]  FAMILY_ID  = 3'b001;
    localparam logic [31:0] BINPG_SEQ  = 32'h3D2A_80A6; // sent MSB byte first
    localparam int          RDY_BIT    = 7;
    localparam int          BINPG_BIT  = 0;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_NODEV   = 3'd1,
        ERR_CAP     = 3'd2,
        ERR_REPROG  = 3'd3,
        ERR_TIMEOUT = 3'd4
    } probe_err_t;

    typedef enum logic [1:0] {
        PH_ID, PH_POLL, PH_CFG
    } xfer_phase_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ID_XFER, ST_ID_GAP, ST_POLL_XFER,
        ST_POLL_GAP, ST_CFG_XFER, ST_CFG_GAP, ST_REPORT
    } probe_state_t;
endpackage

// File: rtl/fid_geom_decode.sv
// Capacity-code to geometry decoder (combinational).
// Assumes the family field was already checked by the caller.
module fid_geom_decode
    import fid_pkg::*;
(
    input  logic [4:0]         cap_code,
    output logic               known,
    output logic [SHIFT_W-1:0] shift,
    output logic [COUNT_W-1:0] count
);
    // Map each supported code to its page shift and page count
    always_comb begin
        known = 1'b1;
        shift = SHIFT_W'(8);
        count = '0;
        case (cap_code)
            5'd2: count = COUNT_W'(512);
            5'd3: count = COUNT_W'(1024);
            5'd4: count = COUNT_W'(2048);
            5'd5: count = COUNT_W'(4096);
            5'd6: begin shift = SHIFT_W'(9);  count = COUNT_W'(4096); end
            5'd7: begin shift = SHIFT_W'(9);  count = COUNT_W'(8192); end
            5'd8: begin shift = SHIFT_W'(10); count = COUNT_W'(8192); end
            default: begin known = 1'b0; shift = '0; end
        endcase
    end
endmodule

// File: rtl/fid_tx_select.sv
// Chooses the outgoing byte from the transfer phase and byte index.
// Assumes windows of at most four bytes.
module fid_tx_select
    import fid_pkg::*;
(
    input  xfer_phase_t phase,
    input  logic [1:0]  idx,
    output logic [7:0]  tx_byte
);
    // Opcode first, fill bytes after; the configuration window walks its sequence
    always_comb begin
        case (phase)
            PH_ID:   tx_byte = (idx == 2'd0) ? OPC_IDENT  : FILL_BYTE;
            PH_POLL: tx_byte = (idx == 2'd0) ? OPC_STATUS : FILL_BYTE;
            default: tx_byte = BINPG_SEQ[8*(3 - int'(idx)) +: 8];
        endcase
    end
endmodule

// File: rtl/fid_poll_budget.sv
// Counts busy status polls and flags the last one allowed.
// Assumes MAX_POLLS >= 1; clear has priority over step.
module fid_poll_budget #(
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] cnt_q;

    // Busy-poll counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (step)       cnt_q <= cnt_q + 1'b1;
    end

    // The poll now being judged is the final one permitted
    assign last = (cnt_q == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/flash_id_probe.sv
// Start-up probe for a page-organised serial flash behind a byte SPI master.
// Reads the ID, decodes the geometry, polls ready, and fixes the page mode once.
// Assumes the shifter acks each request once, with the received byte on spi_rx.
module flash_id_probe
    import fid_pkg::*;
#(
    parameter int MAX_POLLS = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               done,
    output logic               ok,
    output logic [2:0]         err_code,
    output logic [SHIFT_W-1:0] page_shift,
    output logic [COUNT_W-1:0] page_count,
    output logic [SIZE_W-1:0]  page_size,
    output logic               reprog_issued,
    output logic [7:0]         status_byte,
    output logic               spi_cs,
    output logic               spi_req,
    output logic [7:0]         spi_tx,
    input  logic               spi_ack,
    input  logic [7:0]         spi_rx
);
    probe_state_t       state_q;
    probe_err_t         err_q;
    logic [1:0]         byte_idx;
    logic [7:0]         id_vendor_q;
    logic [7:0]         id_device_q;
    xfer_phase_t        phase;
    logic               geo_known;
    logic [SHIFT_W-1:0] geo_shift;
    logic [COUNT_W-1:0] geo_count;
    logic               poll_clear;
    logic               poll_step;
    logic               poll_last;
    logic               id_match;

    fid_geom_decode u_geom (
        .cap_code (id_device_q[4:0]),
        .known    (geo_known),
        .shift    (geo_shift),
        .count    (geo_count)
    );

    fid_tx_select u_txsel (
        .phase   (phase),
        .idx     (byte_idx),
        .tx_byte (spi_tx)
    );

    fid_poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .step  (poll_step),
        .last  (poll_last)
    );

    // Chip select and request follow the transfer states
    always_comb begin
        spi_cs  = (state_q == ST_ID_XFER) || (state_q == ST_POLL_XFER) ||
                  (state_q == ST_CFG_XFER);
        spi_req = spi_cs;
    end

    // Phase selector for the outgoing byte
    always_comb begin
        case (state_q)
            ST_ID_XFER:   phase = PH_ID;
            ST_POLL_XFER: phase = PH_POLL;
            default:      phase = PH_CFG;
        endcase
    end

    // Poll budget control and identity match
    always_comb begin
        poll_clear = (state_q == ST_ID_GAP);
        poll_step  = (state_q == ST_POLL_GAP) && !status_byte[RDY_BIT] && !poll_last;
        id_match   = (id_vendor_q == VENDOR_ID) && (id_device_q[7:5] == FAMILY_ID);
    end

    assign err_code = err_q;

    // Probe sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            err_q         <= ERR_NONE;
            byte_idx      <= '0;
            id_vendor_q   <= '0;
            id_device_q   <= '0;
            done          <= 1'b0;
            ok            <= 1'b0;
            page_shift    <= '0;
            page_count    <= '0;
            page_size     <= '0;
            reprog_issued <= 1'b0;
            status_byte   <= '0;
        end else begin
            done <= (state_q == ST_REPORT);
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q       <= ST_ID_XFER;
                        byte_idx      <= '0;
                        err_q         <= ERR_NONE;
                        ok            <= 1'b0;
                        reprog_issued <= 1'b0;
                        status_byte   <= '0;
                        page_shift    <= '0;
                        page_count    <= '0;
                        page_size     <= '0;
                        id_vendor_q   <= '0;
                        id_device_q   <= '0;
                    end
                end
                ST_ID_XFER: begin
                    if (spi_ack) begin
                        byte_idx <= byte_idx + 2'd1;
                        if (byte_idx == 2'd1) id_vendor_q <= spi_rx;
                        if (byte_idx == 2'd2) id_device_q <= spi_rx;
                        if (byte_idx == 2'd3) state_q <= ST_ID_GAP;
                    end
                end
                ST_ID_GAP: begin
                    byte_idx <= '0;
                    if (!id_match) begin
                        err_q   <= ERR_NODEV;
                        state_q <= ST_REPORT;
                    end else if (!geo_known) begin
                        err_q   <= ERR_CAP;
                        state_q <= ST_REPORT;
                    end else begin
                        page_shift <= geo_shift;
                        page_count <= geo_count;
                        page_size  <= SIZE_W'(1) << geo_shift;
                        state_q    <= ST_POLL_XFER;
                    end
                end
                ST_POLL_XFER: begin
                    if (spi_ack) begin
                        if (byte_idx == 2'd0) begin
                            byte_idx <= 2'd1;
                        end else begin
                            byte_idx    <= '0;
                            status_byte <= spi_rx;
                            state_q     <= ST_POLL_GAP;
                        end
                    end
                end
                ST_POLL_GAP: begin
                    if (status_byte[RDY_BIT]) begin
                        state_q <= status_byte[BINPG_BIT] ? ST_REPORT : ST_CFG_XFER;
                    end else if (poll_last) begin
                        err_q   <= ERR_TIMEOUT;
                        state_q <= ST_REPORT;
                    end else begin
                        state_q <= ST_POLL_XFER;
                    end
                end
                ST_CFG_XFER: begin
                    if (spi_ack) begin
                        byte_idx <= byte_idx + 2'd1;
                        if (byte_idx == 2'd3) state_q <= ST_CFG_GAP;
                    end
                end
                ST_CFG_GAP: begin
                    reprog_issued <= 1'b1;
                    err_q         <= ERR_REPROG;
                    state_q       <= ST_REPORT;
                end
                default: begin
                    ok      <= (err_q == ERR_NONE);
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/fid_probe_chk.sv
// Protocol and result checks for flash_id_probe, attached by bind.
module fid_probe_chk
    import fid_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic               ok,
    input logic [2:0]         err_code,
    input logic [SHIFT_W-1:0] page_shift,
    input logic [SIZE_W-1:0]  page_size,
    input logic               reprog_issued,
    input logic               spi_cs,
    input logic               spi_req,
    input logic               spi_ack,
    input logic [7:0]         spi_tx
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    ok_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok == (err_code == 3'd0)));

    // R8
    reprog_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && reprog_issued) |-> (err_code == 3'd3));

    // R4
    size_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (page_size == (SIZE_W'(1) << page_shift)));

    // R1
    cs_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !spi_cs);
endmodule

bind flash_id_probe fid_probe_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .done          (done),
    .ok            (ok),
    .err_code      (err_code),
    .page_shift    (page_shift),
    .page_size     (page_size),
    .reprog_issued (reprog_issued),
    .spi_cs        (spi_cs),
    .spi_req       (spi_req),
    .spi_ack       (spi_ack),
    .spi_tx        (spi_tx)
);

// File: tb/flash_id_probe_bench.sv
`timescale 1ns/1ps
module flash_id_probe_bench;
    localparam int MAXP = 8;
    localparam int NV   = 15;

    typedef struct packed {
        logic [7:0]  vendor;
        logic [7:0]  device;
        logic [7:0]  busy;
        logic [7:0]  fin;
        logic [2:0]  err;
        logic [3:0]  shift;
        logic [13:0] count;
        logic        reprog;
    } vec_t;

    // vendor, device, busy polls, final status, err, shift, count, reprog
    localparam vec_t VECS [NV] = '{
        '{8'h1F, 8'h26, 8'd0,  8'h81, 3'd0, 4'd9,  14'd4096, 1'b0}, // R4
        '{8'h1F, 8'h22, 8'd1,  8'h81, 3'd0, 4'd8,  14'd512,  1'b0}, // R4 R6
        '{8'h1F, 8'h23, 8'd0,  8'hBD, 3'd0, 4'd8,  14'd1024, 1'b0}, // R4
        '{8'h1F, 8'h24, 8'd0,  8'h81, 3'd0, 4'd8,  14'd2048, 1'b0}, // R4
        '{8'h1F, 8'h25, 8'd0,  8'h81, 3'd0, 4'd8,  14'd4096, 1'b0}, // R4
        '{8'h1F, 8'h27, 8'd2,  8'h81, 3'd0, 4'd9,  14'd8192, 1'b0}, // R4 R6
        '{8'h1F, 8'h28, 8'd0,  8'h81, 3'd0, 4'd10, 14'd8192, 1'b0}, // R4
        '{8'h1E, 8'h26, 8'd0,  8'h81, 3'd1, 4'd0,  14'd0,    1'b0}, // R3 vendor
        '{8'h1F, 8'h46, 8'd0,  8'h81, 3'd1, 4'd0,  14'd0,    1'b0}, // R3 family
        '{8'h1F, 8'h29, 8'd0,  8'h81, 3'd2, 4'd0,  14'd0,    1'b0}, // R5
        '{8'h1F, 8'h21, 8'd0,  8'h81, 3'd2, 4'd0,  14'd0,    1'b0}, // R5
        '{8'h1F, 8'h26, 8'd1,  8'h80, 3'd3, 4'd9,  14'd4096, 1'b1}, // R8
        '{8'h1F, 8'h26, 8'd7,  8'h81, 3'd0, 4'd9,  14'd4096, 1'b0}, // R7 last poll ready
        '{8'h1F, 8'h26, 8'd8,  8'h81, 3'd4, 4'd9,  14'd4096, 1'b0}, // R7 exhausted
        '{8'h1F, 8'h25, 8'd20, 8'h81, 3'd4, 4'd8,  14'd4096, 1'b0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done, ok, reprog_issued, spi_cs, spi_req;
    logic [2:0]  err_code;
    logic [3:0]  page_shift;
    logic [13:0] page_count;
    logic [10:0] page_size;
    logic [7:0]  status_byte, spi_tx;
    logic        spi_ack = 1'b0;
    logic [7:0]  spi_rx = 8'h00;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_id_probe #(.MAX_POLLS(MAXP)) u_flash_id_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .ok(ok),
        .err_code(err_code), .page_shift(page_shift), .page_count(page_count),
        .page_size(page_size), .reprog_issued(reprog_issued),
        .status_byte(status_byte), .spi_cs(spi_cs), .spi_req(spi_req),
        .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx)
    );

    // Device model state
    logic [7:0] cur_vendor = 8'h00, cur_device = 8'h00, cur_fin = 8'h00;
    int  cur_busy = 0;
    int  st_base = 0;
    int  n_id = 0, n_st = 0, n_cfg = 0, n_bad = 0;
    int  pend = 0, widx = 0;
    logic prev_cs = 1'b0;
    logic [7:0] win [8];

    function automatic logic [7:0] reply(input int i);
        if (i == 0) return 8'hFF;
        if (win[0] == 8'h9F) begin
            if (i == 1) return cur_vendor;
            if (i == 2) return cur_device;
            return 8'h00;
        end
        if (win[0] == 8'hD7) return ((n_st - st_base) < cur_busy) ? 8'h01 : cur_fin;
        return 8'h00;
    endfunction

    // Byte shifter and flash model with per-window logging
    always @(posedge clk) begin
        spi_ack <= 1'b0;
        prev_cs <= spi_cs;
        if (!rst_n) begin
            pend = 0;
            widx = 0;
        end else if (!spi_cs) begin
            if (prev_cs) begin
                if (win[0] == 8'h9F) begin
                    n_id++;
                    if (widx != 4 || win[1] != 8'hFF || win[2] != 8'hFF || win[3] != 8'hFF) n_bad++;
                end else if (win[0] == 8'hD7) begin
                    n_st++;
                    if (widx != 2 || win[1] != 8'hFF) n_bad++;
                end else if (win[0] == 8'h3D) begin
                    n_cfg++;
                    if (widx != 4 || win[1] != 8'h2A || win[2] != 8'h80 || win[3] != 8'hA6) n_bad++;
                end else n_bad++;
            end
            widx = 0;
        end else if (spi_req && !spi_ack) begin
            if (pend == 1) begin
                pend = 0;
                if (widx < 8) win[widx] = spi_tx;
                spi_ack <= 1'b1;
                spi_rx  <= reply(widx);
                widx++;
            end else pend++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit mid_start);
        int id0, cfg0, bad0, exp_st;
        bit got;
        cur_vendor = v.vendor; cur_device = v.device;
        cur_busy = int'(v.busy); cur_fin = v.fin;
        st_base = n_st; id0 = n_id; cfg0 = n_cfg; bad0 = n_bad;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        got = 0;
        for (int c = 0; c < 4000 && !got; c++) begin
            @(negedge clk);
            start = mid_start && (c == 6);
            if (done) got = 1;
        end
        start = 1'b0;
        chk("R9", "done seen", int'(got), 1);
        if (!got) return;
        chk("R9", "err_code", int'(err_code), int'(v.err));
        chk("R9", "ok", int'(ok), int'(v.err == 3'd0));
        chk("R4", "page_shift", int'(page_shift), int'(v.shift));
        chk("R4", "page_count", int'(page_count), int'(v.count));
        chk("R4", "page_size", int'(page_size), (v.count == 0) ? 0 : (1 << v.shift));
        chk("R8", "reprog_issued", int'(reprog_issued), int'(v.reprog));
        chk("R8", "config windows", n_cfg - cfg0, int'(v.reprog));
        chk("R2", "id windows", n_id - id0, 1);
        chk("R2", "window contents", n_bad - bad0, 0);
        if (v.err == 3'd1 || v.err == 3'd2) exp_st = 0;
        else if (v.err == 3'd4) exp_st = MAXP;
        else exp_st = int'(v.busy) + 1;
        chk((v.err == 3'd4) ? "R7" : "R6", "status polls", n_st - st_base, exp_st);
        chk("R6", "status_byte", int'(status_byte),
            (exp_st == 0) ? 0 : ((v.err == 3'd4) ? 1 : int'(v.fin)));
        chk("R1", "cs at done", int'(spi_cs), 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int dcount, id0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "cs in reset", int'(spi_cs), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1", "cs idle", int'(spi_cs), 0);
        chk("R1", "req idle", int'(spi_req), 0);
        chk("R1", "done idle", int'(done), 0);
        chk("R1", "err idle", int'(err_code), 0);
        chk("R1", "no window without start", n_id + n_st + n_cfg, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R10: start during a running probe is ignored
        id0 = n_id;
        run_vec('{8'h1F, 8'h26, 8'd3, 8'h81, 3'd0, 4'd9, 14'd4096, 1'b0}, 1'b1);
        dcount = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (done) dcount++;
        end
        chk("R10", "extra done after restart attempt", dcount, 0);
        chk("R10", "id windows for one run", n_id - id0, 1);

        // R1: reset mid-probe returns to idle
        cur_busy = 100;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cs after reset mid-run", int'(spi_cs), 0);
        chk("R1", "err after reset mid-run", int'(err_code), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule